// File: doc/BRIEF.md
# Reloadable 16-bit Interval Timer

This block is a down-counting interval timer with a separate reload latch. Software reaches it through four byte-wide registers selected by a 2-bit offset: the low and high halves of the running count, and the low and high halves of the reload latch. A write to the count-high offset commits the latch into the counter and starts a run. Each cycle in which the `tick` clock-enable is high moves the counter down by one. When the counter is at zero and a tick arrives, the run reaches its timeout.

Two mode inputs come from a neighbouring auxiliary-control register, which decodes them from its bits 6 and 7. `aux_free` chooses between one-shot and free-running operation. In free-running mode the counter reloads from the latch at every timeout. `aux_pin_en` hands port B bit 7 over to the timer's output waveform. The timeout flag `irq_flag` is meant to sit at bit 6 of the interrupt-flag register.

All controls and status are plain level signals. There is no stream interface, so no valid/ready back-pressure applies.

Top module: `itmr_top`

## Requirements
- R1: After reset the count and the latch read as zero, `irq_flag` is 0 and the timer output is high. Until the first count-high write the counter ignores `tick`.
- R2: A write to offset 0 (count-low) or offset 2 (latch-low) stores the byte in the latch's low half only. The running count and the flag are unchanged.
- R3: A write to offset 3 (latch-high) stores the byte in the latch's high half only. The running count keeps counting undisturbed.
- R4: A write to offset 1 (count-high) takes effect on the next cycle and does all of the following:
  - stores the byte in the latch's high half;
  - loads the counter with {written byte, latch low byte};
  - clears the flag;
  - starts a run;
  - drives the timer output low.
- R5: Once a run has started, the counter decreases by exactly one in each cycle with `tick` high, and holds in each cycle with `tick` low.
- R6: In one-shot mode (`aux_free`=0), a tick with the counter at zero sets the flag, drives the timer output high and wraps the counter to 16'hFFFF.
- R7: In free-running mode (`aux_free`=1), a tick with the counter at zero reloads the counter from the latch, sets the flag and toggles the timer output. The period is therefore latch+1 ticks.
- R8: In one-shot mode, only the first timeout after a count-high write sets the flag and changes the output. Later wraps change neither.
- R9: A read strobe at offset 0 clears the flag, and reads at other offsets leave it unchanged. A timeout in the same cycle as the read takes precedence, so the flag ends up set.
- R10: `rd_data` shows, without delay, the byte selected by `reg_sel`:
  - offset 0: count low;
  - offset 1: count high;
  - offset 2: latch low;
  - offset 3: latch high.
- R11: With `aux_pin_en`=1, `pb7_oe` is 1 and `pb7_o` carries the timer output. With `aux_pin_en`=0 they follow `port_b7_dir` and `port_b7_data`.
- R12: A count-high write in the same cycle as a tick takes precedence, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| reg_sel | input | 2 | Register offset (0 count-low, 1 count-high, 2 latch-low, 3 latch-high) |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; has a side effect only at offset 0 |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Byte of the selected register |
| aux_free | input | 1 | 1 = free-running, 0 = one-shot (auxiliary-control bit 6) |
| aux_pin_en | input | 1 | 1 = timer drives port B bit 7 (auxiliary-control bit 7) |
| port_b7_data | input | 1 | Ordinary port data for bit 7 |
| port_b7_dir | input | 1 | Ordinary port direction for bit 7 (1 = output) |
| pb7_o | output | 1 | Port B bit 7 output value |
| pb7_oe | output | 1 | Port B bit 7 output enable |
| irq_flag | output | 1 | Timeout flag (interrupt-flag bit 6) |

## Verification
The assertions assume the following about the inputs:
- `reg_sel`, `wr_en`, `rd_en` and `tick` are known, single-cycle qualifiers sampled at the rising edge.
- Reset is applied before the first edge.
- `aux_free` is sampled only in the cycle of a timeout.

The bench changes inputs only a few nanoseconds after each rising edge and returns the strobes to idle after every edge. It never raises a read and a write in the same cycle. It keeps most random reload values small, so that timeouts and free-running reloads happen often within the run.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Register offsets. The count-high position matters: a write there starts a run.
  typedef enum logic [1:0] {
    OFS_CNT_LO = 2'd0,
    OFS_CNT_HI = 2'd1,
    OFS_LAT_LO = 2'd2,
    OFS_LAT_HI = 2'd3
  } itmr_ofs_e;

  localparam int unsigned BYTES_PER_WORD = 2;

endpackage

// File: rtl/itmr_latch.sv
module itmr_latch #(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned NB   = itmr_pkg::BYTES_PER_WORD,
  localparam int unsigned CW   = NB * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    byte_we,
  input  logic [BUS_W-1:0] wr_data,
  output logic [CW-1:0]    latch_q
);

  // One register per byte lane of the reload latch.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BUS_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (byte_we[b]) begin
        lane_q <= wr_data;
      end
    end

    assign latch_q[b*BUS_W +: BUS_W] = lane_q;
  end

  AST_LATCH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|byte_we) |=> $stable(latch_q)); // R2

endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch_val,
  input  logic             free,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             fire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed_q;    // one-shot run may still fire
  logic started_q;  // a run has been started since reset
  logic at_zero;
  logic timeout;

  assign at_zero = (cnt_q == '0);
  assign timeout = tick && started_q && at_zero && !load;
  assign fire_o  = timeout && (free || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      flag_q    <= 1'b0;
      armed_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (load) begin
      cnt_q     <= load_val;
      flag_q    <= 1'b0;
      armed_q   <= 1'b1;
      started_q <= 1'b1;
    end else begin
      if (tick && started_q) begin
        if (at_zero) begin
          cnt_q <= free ? latch_val : '1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (fire_o) begin
        flag_q <= 1'b1;
      end else if (clr) begin
        flag_q <= 1'b0;
      end
      if (timeout && !free) begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)) && !flag_q); // R4
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && tick && !load && !at_zero) |=> cnt_q == $past(cnt_q) - ONE); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q)); // R5
  AST_ONESHOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !free) |=> (&cnt_q) && !armed_q); // R6
  AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && free) |=> cnt_q == $past(latch_val)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> flag_q); // R6
  AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!free && !armed_q && !load) |=> !$rose(flag_q)); // R8
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire_o && !load) |=> !flag_q); // R9

endmodule

// File: rtl/itmr_pin.sv
module itmr_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fire,
  input  logic free,
  input  logic pin_en,
  input  logic port_b7_data,
  input  logic port_b7_dir,
  output logic pb7_o,
  output logic pb7_oe
);

  logic tout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tout_q <= 1'b1;
    end else if (load) begin
      tout_q <= 1'b0;
    end else if (fire) begin
      tout_q <= free ? !tout_q : 1'b1;
    end
  end

  always_comb begin
    if (pin_en) begin
      pb7_o  = tout_q;
      pb7_oe = 1'b1;
    end else begin
      pb7_o  = port_b7_data;
      pb7_oe = port_b7_dir;
    end
  end

  AST_PIN_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tout_q); // R4
  AST_PIN_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !free && !load) |=> tout_q); // R6
  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && free && !load) |=> tout_q != $past(tout_q)); // R7

endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned CNT_W = itmr_pkg::BYTES_PER_WORD * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic             aux_free,
  input  logic             aux_pin_en,
  input  logic             port_b7_data,
  input  logic             port_b7_dir,
  output logic             pb7_o,
  output logic             pb7_oe,
  output logic             irq_flag
);
  import itmr_pkg::*;

  itmr_ofs_e        ofs;
  logic [1:0]       byte_we;
  logic             load;
  logic             rd_clr;
  logic             fire;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign ofs        = itmr_ofs_e'(reg_sel);
  assign load       = wr_en && (ofs == OFS_CNT_HI);
  assign byte_we[0] = wr_en && ((ofs == OFS_CNT_LO) || (ofs == OFS_LAT_LO));
  assign byte_we[1] = wr_en && ((ofs == OFS_CNT_HI) || (ofs == OFS_LAT_HI));
  assign rd_clr     = rd_en && (ofs == OFS_CNT_LO);
  assign load_val   = {wr_data, latch_q[BUS_W-1:0]};

  itmr_latch #(.BUS_W(BUS_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (byte_we),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_val  (load_val),
    .latch_val (latch_q),
    .free      (aux_free),
    .clr       (rd_clr),
    .cnt_q     (cnt_q),
    .flag_q    (irq_flag),
    .fire_o    (fire)
  );

  itmr_pin u_pin (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .fire         (fire),
    .free         (aux_free),
    .pin_en       (aux_pin_en),
    .port_b7_data (port_b7_data),
    .port_b7_dir  (port_b7_dir),
    .pb7_o        (pb7_o),
    .pb7_oe       (pb7_oe)
  );

  always_comb begin
    unique case (ofs)
      OFS_CNT_LO: rd_data = cnt_q[BUS_W-1:0];
      OFS_CNT_HI: rd_data = cnt_q[CNT_W-1:BUS_W];
      OFS_LAT_LO: rd_data = latch_q[BUS_W-1:0];
      default:    rd_data = latch_q[CNT_W-1:BUS_W];
    endcase
  end

  AST_LATCH_HI_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_LAT_HI && !tick) |=> $stable(cnt_q)); // R3
  AST_START_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tick) |=> cnt_q == {$past(wr_data), $past(latch_q[BUS_W-1:0])}); // R12

endmodule

// File: tb/itmr_tb.sv
`timescale 1ns/1ps
module itmr_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       aux_free = 1'b0;
  logic       aux_pin_en = 1'b1;
  logic       port_b7_data = 1'b0;
  logic       port_b7_dir = 1'b0;
  logic       pb7_o;
  logic       pb7_oe;
  logic       irq_flag;

  always #10 clk = !clk;

  itmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_sel(reg_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .aux_free(aux_free), .aux_pin_en(aux_pin_en),
    .port_b7_data(port_b7_data), .port_b7_dir(port_b7_dir),
    .pb7_o(pb7_o), .pb7_oe(pb7_oe), .irq_flag(irq_flag)
  );

  int n_checks = 0;
  int n_fail = 0;

  // Reference state, derived from the requirements
  logic [15:0] m_cnt = 16'h0000;
  logic [15:0] m_lat = 16'h0000;
  bit m_flag = 1'b0, m_out = 1'b1, m_armed = 1'b0, m_started = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] s);
    case (s)
      2'd0: return m_cnt[7:0];
      2'd1: return m_cnt[15:8];
      2'd2: return m_lat[7:0];
      default: return m_lat[15:8];
    endcase
  endfunction

  // One clock cycle with the given strobes; updates the reference model.
  task automatic cyc(input bit w, input bit r, input logic [1:0] s,
                     input logic [7:0] d, input bit tk);
    logic [15:0] nc, nl;
    bit nf, no, na, ns, to, fire;
    nc = m_cnt; nl = m_lat; nf = m_flag; no = m_out; na = m_armed; ns = m_started;
    if (w && s == 2'd1) begin
      nl[15:8] = d; nc = {d, m_lat[7:0]}; nf = 1'b0; na = 1'b1; ns = 1'b1; no = 1'b0;
    end else begin
      if (w && (s == 2'd0 || s == 2'd2)) nl[7:0] = d;
      if (w && s == 2'd3) nl[15:8] = d;
      to = tk && m_started && (m_cnt == 16'h0000);
      fire = to && (aux_free || m_armed);
      if (tk && m_started) nc = (m_cnt == 16'h0000) ? (aux_free ? m_lat : 16'hFFFF) : m_cnt - 16'h0001;
      if (fire) nf = 1'b1; else if (r && s == 2'd0) nf = 1'b0;
      if (fire) no = aux_free ? !m_out : 1'b1;
      if (to && !aux_free) na = 1'b0;
    end
    wr_en = w; rd_en = r; reg_sel = s; wr_data = d; tick = tk;
    @(posedge clk);
    #2;
    wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    m_cnt = nc; m_lat = nl; m_flag = nf; m_out = no; m_armed = na; m_started = ns;
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s);
      #1;
      chk({tag, " R10 rd_data"}, int'(rd_data), int'(exp_byte(2'(s))));
    end
    chk({tag, " irq_flag"}, int'(irq_flag), int'(m_flag));
    chk({tag, " R11 pb7_o"}, int'(pb7_o), int'(aux_pin_en ? m_out : port_b7_data));
    chk({tag, " R11 pb7_oe"}, int'(pb7_oe), int'(aux_pin_en ? 1'b1 : port_b7_dir));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(64'd200000 * 20);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state, ticks ignored before the first start
    check_all("R1 reset");
    cyc(0, 0, 0, 8'h00, 1);
    cyc(0, 0, 0, 8'h00, 1);
    check_all("R1 idle-ticks");
    chk("R1 pin high", int'(pb7_o), 1);

    // R2: count-low write only fills the latch
    cyc(1, 0, 0, 8'h03, 0);
    reg_sel = 2'd2; #1; chk("R2 latch lo", int'(rd_data), 8'h03);
    reg_sel = 2'd0; #1; chk("R2 count untouched", int'(rd_data), 8'h00);
    // R4: start
    cyc(1, 0, 1, 8'h00, 0);
    reg_sel = 2'd0; #1; chk("R4 count loaded", int'(rd_data), 8'h03);
    chk("R4 flag clear", int'(irq_flag), 0);
    chk("R4 pin low", int'(pb7_o), 0);
    // R5 then R6
    repeat (3) cyc(0, 0, 0, 8'h00, 1);
    cyc(0, 0, 0, 8'h00, 0);
    reg_sel = 2'd0; #1; chk("R5 count at zero", int'(rd_data), 8'h00);
    cyc(0, 0, 0, 8'h00, 1);
    chk("R6 flag set", int'(irq_flag), 1);
    chk("R6 pin high", int'(pb7_o), 1);
    reg_sel = 2'd1; #1; chk("R6 wrap hi", int'(rd_data), 8'hFF);
    check_all("R6 one-shot");
    // R9: reading offset 1 keeps the flag, offset 0 clears it
    cyc(0, 1, 1, 8'h00, 0);
    chk("R9 other read keeps flag", int'(irq_flag), 1);
    cyc(0, 1, 0, 8'h00, 0);
    chk("R9 read low clears", int'(irq_flag), 0);
    // R3: latch-high write while counting
    cyc(1, 0, 3, 8'h12, 1);
    reg_sel = 2'd0; #1; chk("R3 count keeps running", int'(rd_data), 8'hFE);
    reg_sel = 2'd3; #1; chk("R3 latch hi", int'(rd_data), 8'h12);
    // R8: a second wrap does not set the flag again
    for (int i = 0; i < 65535; i++) cyc(0, 0, 0, 8'h00, 1);
    chk("R8 no second flag", int'(irq_flag), 0);
    chk("R8 pin stays high", int'(pb7_o), 1);
    check_all("R8 after wrap");
    // R12: start beats a same-cycle tick
    cyc(1, 0, 1, 8'h00, 1);
    reg_sel = 2'd0; #1; chk("R12 tick ignored", int'(rd_data), 8'h03);
    // R7: free-running, latch 2 -> period 3
    aux_free = 1'b1;
    cyc(1, 0, 2, 8'h02, 0);
    cyc(1, 0, 1, 8'h00, 0);
    repeat (3) cyc(0, 0, 0, 8'h00, 1);
    reg_sel = 2'd0; #1; chk("R7 reload", int'(rd_data), 8'h02);
    chk("R7 flag", int'(irq_flag), 1);
    chk("R7 first toggle", int'(pb7_o), 1);
    repeat (3) cyc(0, 0, 0, 8'h00, 1);
    chk("R7 second toggle", int'(pb7_o), 0);
    // R9: timeout in the same cycle as the clearing read wins
    cyc(0, 0, 0, 8'h00, 1);
    cyc(0, 0, 0, 8'h00, 1);
    cyc(0, 1, 0, 8'h00, 1);
    chk("R9 timeout wins", int'(irq_flag), 1);
    // R11: pass-through when the timer does not own the pin
    aux_pin_en = 1'b0; port_b7_data = 1'b1; port_b7_dir = 1'b0; #1;
    chk("R11 data pass", int'(pb7_o), 1);
    chk("R11 dir pass", int'(pb7_oe), 0);
    aux_pin_en = 1'b1; #1;
    chk("R11 timer owns pin", int'(pb7_oe), 1);

    // Random phase covering R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int k = 0; k < 4000; k++) begin
      int unsigned op;
      logic [1:0] s;
      logic [7:0] d;
      op = $urandom % 16;
      s = 2'($urandom % 4);
      d = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 6);
      if (s == 2'd1 || s == 2'd3) d = ($urandom % 16 == 0) ? 8'h01 : 8'h00;
      if ($urandom % 150 == 0) aux_free = !aux_free;
      if ($urandom % 100 == 0) aux_pin_en = !aux_pin_en;
      port_b7_data = 1'($urandom);
      port_b7_dir = 1'($urandom);
      cyc(op < 2, op == 2, s, d, 1'($urandom));
      check_all("R5 R7 random");
    end
    finish_run();
  end

endmodule